// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a serial slave on a two-wire bus that lets a host read and write a small bank of 8-bit registers. The host first sends a 7-bit device address and a direction bit. On a write it then sends a subaddress, which selects the register that the following data bytes go to. A read returns data from the register last selected. An internal pointer steps to the next register after every data byte, so a host can write or read several consecutive registers in one transfer. A transfer can also touch a single register alone.

The block runs entirely in the system clock domain. It oversamples the bus lines through a synchroniser and detects start, stop and clock edges from the sampled values. The data line is open drain: the block only ever asks for the line to be pulled low. Six registers are writable and appear on a parallel output. Two more mirror status inputs and cannot be written. Register 0 selects between two mutually exclusive operating modes, and the block flags the case where both are requested.

A start or a stop seen at any point ends the current activity at once. A subaddress outside the bank is refused without an acknowledge.

Top module: `cfg_i2c_slave`

## Requirements
- R1: While reset is high and after it is released, `sda_pull_o` is low, all six writable registers read 0 and the three mode outputs are low.
- R2: The first byte after a start carries the 7-bit device address (default 0x3A), most significant bit first, followed by the direction bit (1 = read). Only a matching address is acknowledged. On a mismatch the block stays off the bus until the next start, so later bytes get no acknowledge, no register changes and read data reads as all ones.
- R3: In a write, the byte after the address is the subaddress, and each data byte that follows is stored at the pointer, which then advances. Every accepted byte is acknowledged, and a single data byte changes only its own register. Writable register k appears on `cfg_regs_o[8k+7:8k]`.
- R4: A subaddress of 8 or more gets no acknowledge. The block returns to idle, ignores the rest of that transfer and keeps the pointer it had before.
- R5: A read starts at the last subaddress that was set and sends each byte most significant bit first. The pointer advances after every byte the host acknowledges.
- R6: Once a read reaches register 7, further acknowledged bytes keep returning register 7. A no-acknowledge from the host ends the read and releases the data line.
- R7: Register 6 returns `status_i[7:0]` and register 7 returns `status_i[15:8]`. Writes to either are acknowledged but change nothing, including a burst write that runs past the end of the bank.
- R8: A stop at any point returns the block to idle, and a partly received data byte is discarded.
- R9: A start at any point, including in the middle of a byte, restarts the address phase. A stop followed by a start within one clock-high period is handled as both.
- R10: The block changes `sda_pull_o` only while the sampled clock line is low. The one exception is the release forced by a start or stop.
- R11: Register 0 bit 0 alone sets `lock_ref_en_o`, and bit 1 alone sets `fine_rate_en_o`. When both bits are set, `mode_conflict_o` is high and both enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_pull_o | output | 1 | High to pull the data line low, low to release it |
| status_i | input | 16 | Contents of the two read-only registers (6 low byte, 7 high byte) |
| cfg_regs_o | output | 48 | Writable registers 0 to 5, register k in bits 8k+7:8k |
| lock_ref_en_o | output | 1 | Lock-to-reference mode enable |
| fine_rate_en_o | output | 1 | Fine rate readback mode enable |
| mode_conflict_o | output | 1 | Both mode bits set; neither mode is enabled |

## Verification
The assertions check on every cycle that the pull output stays steady through each clock-high period apart from start and stop, and that a stop always lands in idle and a start in the address phase. They also check that a no-acknowledge after a read byte ends the read, that the pointer never leaves the bank, and that a write aimed at a status register leaves the writable outputs untouched. The bench scenarios are what show the data paths and the protocol outcomes: register contents after single and burst writes, bytes returned by single and saturating burst reads, and the lack of acknowledge for foreign addresses and bad subaddresses. They also show that aborted or restarted transfers leave registers unchanged, and how the mode outputs decode register 0.

// File: rtl/cfg_i2c_pkg.sv
`timescale 1ns/1ps
package cfg_i2c_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SUB,
        ST_WDATA,
        ST_ACK,
        ST_RDATA,
        ST_RACK
    } bus_state_e;

    // Sampled bus levels and the events derived from them.
    typedef struct packed {
        logic scl;
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } line_ev_t;

    // Pointer step that stops at the last register.
    function automatic logic [BYTE_W-1:0] ptr_step(input logic [BYTE_W-1:0] cur,
                                                   input logic [BYTE_W-1:0] last);
        return (cur >= last) ? last : cur + 8'd1;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
module i2c_line_sync
    import cfg_i2c_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);

    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] scl_chain;
    logic [MSB:0] sda_chain;
    logic         scl_q;
    logic         sda_q;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_chain <= '1;
                    sda_chain <= '1;
                end else begin
                    scl_chain <= scl_i;
                    sda_chain <= sda_i;
                end
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_chain <= '1;
                    sda_chain <= '1;
                end else begin
                    scl_chain <= {scl_chain[MSB-1:0], scl_i};
                    sda_chain <= {sda_chain[MSB-1:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_chain[MSB];
            sda_q <= sda_chain[MSB];
        end
    end

    always_comb begin
        ev.scl   = scl_chain[MSB];
        ev.sda   = sda_chain[MSB];
        ev.rise  = scl_chain[MSB] & ~scl_q;
        ev.fall  = ~scl_chain[MSB] & scl_q;
        ev.start = scl_chain[MSB] & scl_q & sda_q & ~sda_chain[MSB];
        ev.stop  = scl_chain[MSB] & scl_q & ~sda_q & sda_chain[MSB];
    end

endmodule

// File: rtl/cfg_reg_bank.sv
`timescale 1ns/1ps
module cfg_reg_bank
    import cfg_i2c_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int NUM_RO   = 2,
    localparam int NUM_RW  = NUM_REGS - NUM_RO,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [BYTE_W-1:0]        wr_data,
    input  logic [IDX_W-1:0]         rd_idx,
    input  logic [NUM_RO*BYTE_W-1:0] status_i,
    output logic [BYTE_W-1:0]        rd_data,
    output logic [NUM_RW*BYTE_W-1:0] cfg_o
);

    logic [BYTE_W-1:0] rw_q [NUM_RW];

    always_ff @(posedge clk) begin
        for (int k = 0; k < NUM_RW; k++) begin
            if (rst) begin
                rw_q[k] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(k)) begin
                rw_q[k] <= wr_data;
            end
        end
    end

    generate
        for (genvar g = 0; g < NUM_RW; g++) begin : g_out
            assign cfg_o[g*BYTE_W +: BYTE_W] = rw_q[g];
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_RW; k++) begin
            if (rd_idx == IDX_W'(k)) rd_data = rw_q[k];
        end
        for (int k = 0; k < NUM_RO; k++) begin
            if (rd_idx == IDX_W'(NUM_RW + k)) rd_data = status_i[k*BYTE_W +: BYTE_W];
        end
    end

endmodule

// File: rtl/i2c_xfer_fsm.sv
`timescale 1ns/1ps
module i2c_xfer_fsm
    import cfg_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h3A,
    parameter int         NUM_REGS = 8,
    localparam int        IDX_W    = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  line_ev_t          ev,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              sda_pull
);

    localparam logic [BYTE_W-1:0] LAST_IDX = BYTE_W'(NUM_REGS - 1);

    bus_state_e        state;
    bus_state_e        after_ack;
    logic [2:0]        bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] ptr;
    logic              drv;
    logic              rack_ok;
    logic [BYTE_W-1:0] rx_byte;

    assign rx_byte = {shreg[BYTE_W-2:0], ev.sda};
    assign rd_idx  = ptr[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            after_ack <= ST_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            ptr       <= '0;
            drv       <= 1'b0;
            rack_ok   <= 1'b0;
            wr_en     <= 1'b0;
            wr_idx    <= '0;
            wr_data   <= '0;
        end else begin
            wr_en <= 1'b0;
            if (ev.stop) begin
                state   <= ST_IDLE;
                drv     <= 1'b0;
                rack_ok <= 1'b0;
            end else if (ev.start) begin
                state   <= ST_ADDR;
                bitcnt  <= '0;
                drv     <= 1'b0;
                rack_ok <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_SUB, ST_WDATA: begin
                        if (ev.rise) begin
                            shreg  <= rx_byte;
                            bitcnt <= bitcnt + 3'd1;
                            if (bitcnt == 3'd7) begin
                                if (state == ST_ADDR) begin
                                    if (rx_byte[7:1] == DEV_ADDR) begin
                                        state     <= ST_ACK;
                                        after_ack <= rx_byte[0] ? ST_RDATA : ST_SUB;
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end else if (state == ST_SUB) begin
                                    if (rx_byte <= LAST_IDX) begin
                                        ptr       <= rx_byte;
                                        state     <= ST_ACK;
                                        after_ack <= ST_WDATA;
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end else begin
                                    wr_en     <= 1'b1;
                                    wr_idx    <= ptr[IDX_W-1:0];
                                    wr_data   <= rx_byte;
                                    ptr       <= ptr_step(ptr, LAST_IDX);
                                    state     <= ST_ACK;
                                    after_ack <= ST_WDATA;
                                end
                            end
                        end
                    end
                    ST_ACK: begin
                        if (ev.fall) begin
                            if (!drv) begin
                                drv <= 1'b1;
                            end else begin
                                drv    <= 1'b0;
                                state  <= after_ack;
                                bitcnt <= '0;
                                if (after_ack == ST_RDATA) shreg <= rd_data;
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (ev.fall) begin
                            if (bitcnt == 3'd7) begin
                                state <= ST_RACK;
                            end else begin
                                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                                bitcnt <= bitcnt + 3'd1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (ev.rise) begin
                            if (ev.sda) begin
                                state <= ST_IDLE;
                            end else begin
                                ptr     <= ptr_step(ptr, LAST_IDX);
                                rack_ok <= 1'b1;
                            end
                        end else if (ev.fall && rack_ok) begin
                            rack_ok <= 1'b0;
                            shreg   <= rd_data;
                            bitcnt  <= '0;
                            state   <= ST_RDATA;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_pull = (state == ST_ACK && drv) || (state == ST_RDATA && !shreg[BYTE_W-1]);

    // R8: a stop always lands in idle
    p_stop_to_idle_r8: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> state == ST_IDLE);

    // R9: a start always restarts the address phase
    p_start_restarts_r9: assert property (@(posedge clk) disable iff (rst)
        (ev.start && !ev.stop) |=> state == ST_ADDR);

    // R10: pull output steady through a clock-high period
    p_pull_steady_high_r10: assert property (@(posedge clk) disable iff (rst)
        (ev.scl && $past(ev.scl) && !$past(ev.start) && !$past(ev.stop)) |-> $stable(sda_pull));

    // R6: a no-acknowledge after a read byte ends the read
    p_nack_ends_read_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RACK && ev.rise && ev.sda) |=> state == ST_IDLE);

    // R5: pointer stays inside the bank
    p_ptr_in_bank_r5: assert property (@(posedge clk) disable iff (rst)
        ptr <= LAST_IDX);

endmodule

// File: rtl/cfg_i2c_slave.sv
`timescale 1ns/1ps
module cfg_i2c_slave
    import cfg_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h3A,
    parameter int         NUM_REGS    = 8,
    parameter int         NUM_RO      = 2,
    parameter int         SYNC_STAGES = 2,
    localparam int        NUM_RW      = NUM_REGS - NUM_RO,
    localparam int        IDX_W       = $clog2(NUM_REGS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     scl_i,
    input  logic                     sda_i,
    output logic                     sda_pull_o,
    input  logic [NUM_RO*BYTE_W-1:0] status_i,
    output logic [NUM_RW*BYTE_W-1:0] cfg_regs_o,
    output logic                     lock_ref_en_o,
    output logic                     fine_rate_en_o,
    output logic                     mode_conflict_o
);

    line_ev_t          ev;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [BYTE_W-1:0] wr_data;
    logic [IDX_W-1:0]  rd_idx;
    logic [BYTE_W-1:0] rd_data;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_xfer_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_idx   (rd_idx),
        .sda_pull (sda_pull_o)
    );

    cfg_reg_bank #(.NUM_REGS(NUM_REGS), .NUM_RO(NUM_RO)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_idx   (rd_idx),
        .status_i (status_i),
        .rd_data  (rd_data),
        .cfg_o    (cfg_regs_o)
    );

    // Mode decode from register 0: a double request enables nothing.
    logic [1:0] mode_bits;
    assign mode_bits       = cfg_regs_o[1:0];
    assign lock_ref_en_o   = mode_bits == 2'b01;
    assign fine_rate_en_o  = mode_bits == 2'b10;
    assign mode_conflict_o = mode_bits == 2'b11;

    // R7: a write aimed at a status register leaves the writable bank alone
    p_ro_write_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx >= IDX_W'(NUM_RW)) |=> $stable(cfg_regs_o));

endmodule

// File: tb/test_cfg_i2c_slave.sv
`timescale 1ns/1ps
module test_cfg_i2c_slave;

    localparam logic [6:0] DEV  = 7'h3A;
    localparam int         NREG = 8;
    localparam int         NRW  = 6;
    localparam int         Q    = 8;
    localparam logic [7:0] STAT6 = 8'h5C;
    localparam logic [7:0] STAT7 = 8'hC3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_line;
    logic        sda_pull_o;
    logic [15:0] status_i;
    logic [47:0] cfg_regs_o;
    logic        lock_ref_en_o, fine_rate_en_o, mode_conflict_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [7:0] exp_r [NREG];
    logic [7:0] wbuf  [8];
    logic [7:0] rbuf  [8];

    always #2.5 clk = ~clk;

    assign status_i = {STAT7, STAT6};
    assign sda_line = m_sda & ~sda_pull_o;

    cfg_i2c_slave #(.DEV_ADDR(DEV)) i_cfg_i2c_slave (
        .clk             (clk),
        .rst             (rst),
        .scl_i           (m_scl),
        .sda_i           (sda_line),
        .sda_pull_o      (sda_pull_o),
        .status_i        (status_i),
        .cfg_regs_o      (cfg_regs_o),
        .lock_ref_en_o   (lock_ref_en_o),
        .fine_rate_en_o  (fine_rate_en_o),
        .mode_conflict_o (mode_conflict_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic wr_bit(input logic b);
        m_sda = b; qw();
        m_scl = 1'b1; qw(); qw();
        m_scl = 1'b0; qw();
    endtask

    task automatic rd_bit(output logic b);
        logic late;
        m_sda = 1'b1; qw();
        m_scl = 1'b1; qw();
        b = sda_line; qw();
        late = sda_line;
        check("R10 line steady while clock high", late, b);
        m_scl = 1'b0; qw();
    endtask

    task automatic start_c();
        m_sda = 1'b1; qw();
        m_scl = 1'b1; qw();
        m_sda = 1'b0; qw();
        m_scl = 1'b0; qw();
    endtask

    task automatic stop_c();
        m_sda = 1'b0; qw();
        m_scl = 1'b1; qw();
        m_sda = 1'b1; qw();
    endtask

    task automatic stop_start_c();
        m_sda = 1'b0; qw();
        m_scl = 1'b1; qw();
        m_sda = 1'b1; qw();
        m_sda = 1'b0; qw();
        m_scl = 1'b0; qw();
    endtask

    task automatic send_byte(input logic [7:0] d, output bit ack);
        logic b;
        for (int i = 7; i >= 0; i--) wr_bit(d[i]);
        rd_bit(b);
        ack = !b;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic nack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            rd_bit(b);
            d[i] = b;
        end
        wr_bit(nack);
    endtask

    // Write n bytes of wbuf from subaddress sub; the model mirrors the pointer.
    task automatic write_xfer(input logic [7:0] sub, input int n, output bit all_ack);
        bit a;
        int p;
        all_ack = 1'b1;
        start_c();
        send_byte({DEV, 1'b0}, a); all_ack &= a;
        send_byte(sub, a);         all_ack &= a;
        p = int'(sub);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], a); all_ack &= a;
            if (p < NRW) exp_r[p] = wbuf[i];
            if (p < NREG - 1) p++;
        end
        stop_c();
    endtask

    task automatic read_xfer(input logic [7:0] sub, input bit set_sub, input int n, output bit all_ack);
        bit a;
        all_ack = 1'b1;
        start_c();
        if (set_sub) begin
            send_byte({DEV, 1'b0}, a); all_ack &= a;
            send_byte(sub, a);         all_ack &= a;
            start_c();
        end
        send_byte({DEV, 1'b1}, a); all_ack &= a;
        for (int i = 0; i < n; i++) recv_byte(rbuf[i], (i == n - 1));
        stop_c();
    endtask

    task automatic check_cfg(input string req);
        for (int k = 0; k < NRW; k++) check(req, cfg_regs_o[k*8 +: 8], exp_r[k]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit ok, a;
        logic [7:0] d;
        logic b;
        for (int k = 0; k < NRW; k++) exp_r[k] = 8'h00;
        exp_r[6] = STAT6;
        exp_r[7] = STAT7;

        repeat (6) @(negedge clk);
        check("R1 pull in reset", sda_pull_o, 1'b0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 pull after reset", sda_pull_o, 1'b0);
        check("R1 regs after reset", cfg_regs_o, 48'h0);
        check("R1 modes after reset", {lock_ref_en_o, fine_rate_en_o, mode_conflict_o}, 3'b000);

        // R3: single-byte write to every writable register
        for (int s = 0; s < NRW; s++) begin
            wbuf[0] = 8'((s * 37 + 11) ^ 8'hA4);
            write_xfer(8'(s), 1, ok);
            check("R3 single write acked", ok, 1'b1);
            check_cfg("R3 single write content");
        end

        // R5: single reads of every register, including status
        for (int s = 0; s < NREG; s++) begin
            read_xfer(8'(s), 1'b1, 1, ok);
            check("R5 single read acked", ok, 1'b1);
            check((s >= NRW) ? "R7 status read" : "R5 single read data", rbuf[0], exp_r[s]);
        end

        // R3: burst write from register 0
        for (int i = 0; i < NRW; i++) wbuf[i] = 8'(8'hF0 - i * 19);
        write_xfer(8'd0, NRW, ok);
        check("R3 burst write acked", ok, 1'b1);
        check_cfg("R3 burst write content");

        // R7: burst from 4 running into the status registers and past the end
        for (int i = 0; i < 5; i++) wbuf[i] = 8'(8'h21 + i * 8'h11);
        write_xfer(8'd4, 5, ok);
        check("R7 writes past writable acked", ok, 1'b1);
        check_cfg("R7 writable bank after overrun");
        read_xfer(8'd6, 1'b1, 2, ok);
        check("R7 reg6 unchanged", rbuf[0], STAT6);
        check("R7 reg7 unchanged", rbuf[1], STAT7);

        // R5 R6: burst read from 5 saturating at register 7
        read_xfer(8'd5, 1'b1, 5, ok);
        check("R5 burst read acked", ok, 1'b1);
        check("R5 burst byte0", rbuf[0], exp_r[5]);
        check("R5 burst byte1", rbuf[1], exp_r[6]);
        check("R6 burst byte2", rbuf[2], exp_r[7]);
        check("R6 burst byte3 held", rbuf[3], exp_r[7]);
        check("R6 burst byte4 held", rbuf[4], exp_r[7]);
        check("R6 line released after nack", sda_pull_o, 1'b0);

        // R2: foreign address, write direction
        start_c();
        send_byte({DEV ^ 7'h01, 1'b0}, a);
        check("R2 foreign address not acked", a, 1'b0);
        send_byte(8'h00, a);
        check("R2 later byte not acked", a, 1'b0);
        send_byte(8'h77, a);
        check("R2 data not acked", a, 1'b0);
        stop_c();
        check_cfg("R2 registers untouched");

        // R2: foreign address, read direction reads all ones
        start_c();
        send_byte({DEV ^ 7'h02, 1'b1}, a);
        check("R2 foreign read not acked", a, 1'b0);
        recv_byte(d, 1'b1);
        check("R2 foreign read line idle", d, 8'hFF);
        stop_c();

        // R4: set pointer to 3 with a read, then refuse bad subaddresses
        read_xfer(8'd3, 1'b1, 1, ok);
        check("R5 read reg3", rbuf[0], exp_r[3]);
        for (int s = 8; s < 18; s++) begin
            logic [7:0] bad;
            bad = (s < 16) ? 8'(s) : ((s == 16) ? 8'h80 : 8'hFF);
            start_c();
            send_byte({DEV, 1'b0}, a);
            check("R4 address acked", a, 1'b1);
            send_byte(bad, a);
            check("R4 bad subaddress not acked", a, 1'b0);
            send_byte(8'h5A, a);
            check("R4 data after bad subaddress not acked", a, 1'b0);
            stop_c();
        end
        check_cfg("R4 registers untouched");
        read_xfer(8'd0, 1'b0, 1, ok);
        check("R4 pointer kept after refusal", rbuf[0], exp_r[3]);

        // R8: stop in the middle of a data byte
        start_c();
        send_byte({DEV, 1'b0}, a);
        send_byte(8'd2, a);
        for (int i = 0; i < 4; i++) wr_bit(~exp_r[2][7-i]);
        stop_c();
        check_cfg("R8 partial byte discarded");
        check("R8 line released", sda_pull_o, 1'b0);

        // R9: start in the middle of a data byte
        start_c();
        send_byte({DEV, 1'b0}, a);
        send_byte(8'd1, a);
        for (int i = 0; i < 3; i++) wr_bit(~exp_r[1][7-i]);
        start_c();
        send_byte({DEV, 1'b0}, a);
        check("R9 restart address acked", a, 1'b1);
        send_byte(8'd3, a);
        send_byte(8'h3C, a);
        check("R9 write after restart acked", a, 1'b1);
        exp_r[3] = 8'h3C;
        stop_c();
        check_cfg("R9 restart mid-byte");

        // R9: stop then start in one clock-high period
        start_c();
        send_byte({DEV, 1'b0}, a);
        send_byte(8'd2, a);
        send_byte(8'h96, a);
        exp_r[2] = 8'h96;
        stop_start_c();
        send_byte({DEV, 1'b0}, a);
        check("R9 address after stop-start acked", a, 1'b1);
        send_byte(8'd4, a);
        send_byte(8'h69, a);
        check("R9 data after stop-start acked", a, 1'b1);
        exp_r[4] = 8'h69;
        stop_c();
        check_cfg("R9 stop-start content");

        // R11: mode decode over all four codes of register 0 bits 1:0
        for (int m = 0; m < 4; m++) begin
            wbuf[0] = 8'(8'hF0 | m);
            write_xfer(8'd0, 1, ok);
            check("R11 lock_ref_en", lock_ref_en_o, (m == 1));
            check("R11 fine_rate_en", fine_rate_en_o, (m == 2));
            check("R11 mode_conflict", mode_conflict_o, (m == 3));
        end
        check_cfg("R11 register 0 stored");

        rd_bit(b);
        check("R1 idle line high", b, 1'b1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule